// File: doc/BRIEF.md
# Four-voice wavetable mixer

This block is a wavetable synthesizer with four voices. Its sample store is a 1024-byte RAM that holds two tables of 512 bytes. Voices 0 and 1 read the lower table and voices 2 and 3 read the upper table. Each voice keeps a 24-bit phase and a 24-bit increment, both in 9.15 fixed point. A host reaches them through a byte-wide register bus, with every value laid out as a big-endian 32-bit word. The host loads the tables through the same bus.

Each time the `tick` input is asserted while the mode register holds the wavetable value, a sequencer steps through the voices one per cycle. For each voice it adds the increment to the phase, writes the advanced phase back, and uses the advanced phase to fetch an unsigned 8-bit sample. The four samples are summed and the sum is divided by four. The same byte then goes out on both the left and the right output, with a one-cycle `out_valid` pulse.

The sequencer has three states:
- `SEQ_IDLE` waits for a tick. It moves to `SEQ_STEP` only when `tick` is high and the mode is 2.
- `SEQ_STEP` handles one voice per cycle. It moves to `SEQ_EMIT` after the last voice.
- `SEQ_EMIT` registers the mixed result and always returns to `SEQ_IDLE`.

Top module: `wt_mixer`

## Requirements
- R1: After reset, every phase, every increment and the mode register read back 0, `out_valid` is 0, and both outputs are 0.
- R2: The host address map uses big-endian words. Address 8v+b is byte b of the phase of voice v, and 8v+4+b is byte b of its increment; byte 0 is bits 31:24. Address 0x20 is the mode register, held in bits 1:0. Byte 0 of every phase and increment always reads 0, and writes to it are dropped.
- R3: On a tick accepted in mode 2, each voice's phase becomes (phase + increment) mod 2^24. The new value can be read back by the host afterwards.
- R4: The sample for voice v is taken from RAM address 512*(v>>1) + bits 23:15 of that voice's advanced phase.
- R5: `out_left` and `out_right` both equal the sum of the four samples shifted right by 2. `out_valid` is a single-cycle pulse that rises on the fifth rising edge after the edge that accepts the tick.
- R6: While the mode is not 2, a tick starts nothing. No `out_valid` pulse follows, and no phase changes.
- R7: If a host write to byte b of voice k's phase lands in the same cycle as the sequencer's store for voice k, the host write wins. The register ends as the old phase with byte b replaced. Voice k's sample still comes from the advanced phase.
- R8: Addresses 0x400 + a write and read byte a of the sample RAM. The lower table is a = 0..511 and the upper table is a = 512..1023.
- R9: A tick that arrives while a sequence is running is ignored. One tick yields exactly one output.
- R10: A phase that passes 0xFFFFFF wraps modulo 2^24, and the sample offset wraps with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 11 | Host byte address; bit 10 selects the sample RAM |
| host_we | input | 1 | Host write strobe, one byte per cycle |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte for `host_addr`, combinational |
| tick | input | 1 | Sample-rate strobe |
| out_valid | output | 1 | One-cycle pulse marking a new output sample |
| out_left | output | 8 | Left output sample |
| out_right | output | 8 | Right output sample |

## Verification
A host write to a phase register and the sequencer's store of that same phase can fall in the same cycle. To provoke this, the bench asserts `tick` and then counts k+1 falling edges. It then drives a byte write to voice k's phase, so that the write and the store for voice k share one rising edge. The bench checks two things: the mixed output must still reflect the advanced phase of voice k, and a readback of the register must show the old phase with only the written byte replaced.

// File: rtl/wt_pkg.sv
package wt_pkg;

    localparam int WORD_BYTES = 4;
    localparam logic [1:0] MODE_WAVE = 2'd2;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_STEP = 2'd1,
        SEQ_EMIT = 2'd2
    } seq_state_e;

    // Replace one byte of a big-endian 32-bit word (byte 0 = bits 31:24).
    function automatic logic [31:0] put_byte(input logic [31:0] w,
                                             input logic [1:0]  b,
                                             input logic [7:0]  d);
        logic [31:0] r;
        int sh;
        r  = w;
        sh = 8 * (WORD_BYTES - 1 - int'(b));
        r[sh +: 8] = d;
        return r;
    endfunction

    // Select one byte of a big-endian 32-bit word.
    function automatic logic [7:0] get_byte(input logic [31:0] w,
                                            input logic [1:0]  b);
        int sh;
        sh = 8 * (WORD_BYTES - 1 - int'(b));
        return w[sh +: 8];
    endfunction

endpackage

// File: rtl/wt_sample_ram.sv
module wt_sample_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] host_raddr,
    output logic [DW-1:0] host_rdata,
    input  logic [AW-1:0] seq_raddr,
    output logic [DW-1:0] seq_rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign host_rdata = mem[host_raddr];
    assign seq_rdata  = mem[seq_raddr];

endmodule

// File: rtl/wt_voice_regs.sv
module wt_voice_regs
    import wt_pkg::*;
#(
    parameter int VOICES = 4,
    parameter int PH_W   = 24,
    localparam int VIW   = $clog2(VOICES)
) (
    input  logic            clk,
    input  logic            rst_n,
    // host write port
    input  logic            hw_en,
    input  logic [VIW-1:0]  hw_voice,
    input  logic            hw_word,
    input  logic [1:0]      hw_byte,
    input  logic [7:0]      hw_data,
    // host read port (uses the same voice/word/byte fields)
    output logic [7:0]      rd_data,
    // sequencer port
    input  logic [VIW-1:0]  sel_voice,
    output logic [PH_W-1:0] sel_phase,
    output logic [PH_W-1:0] sel_incr,
    input  logic            upd_en,
    input  logic [PH_W-1:0] upd_phase
);

    logic [PH_W-1:0] ph_all  [VOICES];
    logic [PH_W-1:0] inc_all [VOICES];

    for (genvar v = 0; v < VOICES; v++) begin : g_voice
        logic [PH_W-1:0] ph_r;
        logic [PH_W-1:0] inc_r;
        logic [PH_W-1:0] ph_merged;
        logic [PH_W-1:0] inc_merged;
        logic            hit_ph;
        logic            hit_inc;
        logic            own_upd;

        assign hit_ph  = hw_en && (hw_voice == VIW'(v)) && !hw_word && (hw_byte != 2'd0);
        assign hit_inc = hw_en && (hw_voice == VIW'(v)) &&  hw_word && (hw_byte != 2'd0);
        assign own_upd = upd_en && (sel_voice == VIW'(v));

        assign ph_merged  = PH_W'(put_byte(32'(ph_r),  hw_byte, hw_data));
        assign inc_merged = PH_W'(put_byte(32'(inc_r), hw_byte, hw_data));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ph_r  <= '0;
                inc_r <= '0;
            end else begin
                // host byte write has priority over the sequencer store
                if (hit_ph) begin
                    ph_r <= ph_merged;
                end else if (own_upd) begin
                    ph_r <= upd_phase;
                end
                if (hit_inc) begin
                    inc_r <= inc_merged;
                end
            end
        end

        assign ph_all[v]  = ph_r;
        assign inc_all[v] = inc_r;
    end

    assign sel_phase = ph_all[sel_voice];
    assign sel_incr  = inc_all[sel_voice];

    always_comb begin
        if (hw_word) begin
            rd_data = get_byte(32'(inc_all[hw_voice]), hw_byte);
        end else begin
            rd_data = get_byte(32'(ph_all[hw_voice]), hw_byte);
        end
    end

endmodule

// File: rtl/wt_seq.sv
module wt_seq
    import wt_pkg::*;
#(
    parameter int VOICES = 4,
    parameter int TABLES = 2,
    parameter int TBL_AW = 9,
    parameter int PH_W   = 24,
    parameter int SMP_W  = 8,
    localparam int VIW    = $clog2(VOICES),
    localparam int TIW    = $clog2(TABLES),
    localparam int RAM_AW = TBL_AW + TIW,
    localparam int VSH    = $clog2(VOICES / TABLES),
    localparam int SUM_W  = SMP_W + VIW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run_en,
    input  logic [PH_W-1:0]   cur_phase,
    input  logic [PH_W-1:0]   cur_incr,
    input  logic [SMP_W-1:0]  sample,
    output logic [VIW-1:0]    vidx,
    output logic              upd_en,
    output logic [PH_W-1:0]   upd_phase,
    output logic [RAM_AW-1:0] rd_addr,
    output logic              busy,
    output logic              out_valid,
    output logic [SMP_W-1:0]  out_left,
    output logic [SMP_W-1:0]  out_right
);

    seq_state_e       state_q, state_d;
    logic [VIW-1:0]   vidx_q;
    logic [SUM_W-1:0] acc_q;
    logic [TIW-1:0]   tbl;
    logic             last_voice;

    assign last_voice = (vidx_q == VIW'(VOICES - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (tick && run_en) state_d = SEQ_STEP;
            SEQ_STEP: if (last_voice)     state_d = SEQ_EMIT;
            SEQ_EMIT:                     state_d = SEQ_IDLE;
            default:                      state_d = SEQ_IDLE;
        endcase
    end

    // phase advance and table addressing for the voice in flight
    always_comb begin
        upd_phase = cur_phase + cur_incr;
        tbl       = TIW'(vidx_q >> VSH);
        rd_addr   = {tbl, upd_phase[PH_W-1 -: TBL_AW]};
        upd_en    = (state_q == SEQ_STEP);
    end

    assign vidx = vidx_q;
    assign busy = (state_q != SEQ_IDLE);

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vidx_q    <= '0;
            acc_q     <= '0;
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (tick && run_en) begin
                        vidx_q <= '0;
                        acc_q  <= '0;
                    end
                end
                SEQ_STEP: begin
                    acc_q  <= acc_q + SUM_W'(sample);
                    vidx_q <= vidx_q + 1'b1;
                end
                SEQ_EMIT: begin
                    out_left  <= SMP_W'(acc_q >> VIW);
                    out_right <= SMP_W'(acc_q >> VIW);
                    out_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wt_mixer.sv
module wt_mixer
    import wt_pkg::*;
#(
    parameter int VOICES = 4,
    parameter int TABLES = 2,
    parameter int TBL_AW = 9,
    parameter int FRAC_W = 15,
    parameter int SMP_W  = 8,
    localparam int PH_W     = TBL_AW + FRAC_W,
    localparam int VIW      = $clog2(VOICES),
    localparam int TIW      = $clog2(TABLES),
    localparam int RAM_AW   = TBL_AW + TIW,
    localparam int HAW      = RAM_AW + 1,
    localparam int REG_AW   = VIW + 3,
    localparam int MODE_OFF = 1 << REG_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HAW-1:0]   host_addr,
    input  logic             host_we,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    input  logic             tick,
    output logic             out_valid,
    output logic [SMP_W-1:0] out_left,
    output logic [SMP_W-1:0] out_right
);

    logic              ram_sel;
    logic              reg_sel;
    logic              mode_sel;
    logic [1:0]        mode_q;
    logic [7:0]        vreg_rd;
    logic [SMP_W-1:0]  ram_host_rd;
    logic [SMP_W-1:0]  ram_seq_rd;
    logic [VIW-1:0]    seq_vidx;
    logic [PH_W-1:0]   seq_cur_phase;
    logic [PH_W-1:0]   seq_cur_incr;
    logic              seq_upd_en;
    logic [PH_W-1:0]   seq_upd_phase;
    logic [RAM_AW-1:0] seq_rd_addr;
    logic              seq_busy;

    // address decode
    assign ram_sel  = host_addr[HAW-1];
    assign reg_sel  = !ram_sel && (host_addr[HAW-2:REG_AW] == '0);
    assign mode_sel = !ram_sel && (host_addr[HAW-2:0] == RAM_AW'(MODE_OFF));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 2'd0;
        end else if (host_we && mode_sel) begin
            mode_q <= host_wdata[1:0];
        end
    end

    always_comb begin
        if (ram_sel) begin
            host_rdata = 8'(ram_host_rd);
        end else if (reg_sel) begin
            host_rdata = vreg_rd;
        end else if (mode_sel) begin
            host_rdata = {6'd0, mode_q};
        end else begin
            host_rdata = 8'd0;
        end
    end

    wt_voice_regs #(
        .VOICES (VOICES),
        .PH_W   (PH_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_en     (host_we && reg_sel),
        .hw_voice  (host_addr[REG_AW-1:3]),
        .hw_word   (host_addr[2]),
        .hw_byte   (host_addr[1:0]),
        .hw_data   (host_wdata),
        .rd_data   (vreg_rd),
        .sel_voice (seq_vidx),
        .sel_phase (seq_cur_phase),
        .sel_incr  (seq_cur_incr),
        .upd_en    (seq_upd_en),
        .upd_phase (seq_upd_phase)
    );

    wt_sample_ram #(
        .AW (RAM_AW),
        .DW (SMP_W)
    ) u_ram (
        .clk        (clk),
        .we         (host_we && ram_sel),
        .waddr      (host_addr[RAM_AW-1:0]),
        .wdata      (SMP_W'(host_wdata)),
        .host_raddr (host_addr[RAM_AW-1:0]),
        .host_rdata (ram_host_rd),
        .seq_raddr  (seq_rd_addr),
        .seq_rdata  (ram_seq_rd)
    );

    wt_seq #(
        .VOICES (VOICES),
        .TABLES (TABLES),
        .TBL_AW (TBL_AW),
        .PH_W   (PH_W),
        .SMP_W  (SMP_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run_en    (mode_q == MODE_WAVE),
        .cur_phase (seq_cur_phase),
        .cur_incr  (seq_cur_incr),
        .sample    (ram_seq_rd),
        .vidx      (seq_vidx),
        .upd_en    (seq_upd_en),
        .upd_phase (seq_upd_phase),
        .rd_addr   (seq_rd_addr),
        .busy      (seq_busy),
        .out_valid (out_valid),
        .out_left  (out_left),
        .out_right (out_right)
    );

endmodule

// File: rtl/wt_mixer_chk.sv
module wt_mixer_chk #(
    parameter int HAW = 11
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick,
    input logic [1:0]     mode,
    input logic           busy,
    input logic           out_valid,
    input logic           reg_sel,
    input logic           ram_sel,
    input logic           host_we,
    input logic [HAW-1:0] host_addr,
    input logic [7:0]     host_wdata,
    input logic [7:0]     host_rdata
);

    // R5
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R5
    out_after_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(busy));

    // R6
    idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tick && mode != 2'd2) |=> !busy);

    // R9
    start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(tick) && $past(mode) == 2'd2));

    // R2
    top_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && host_addr[1:0] == 2'd0) |-> host_rdata == 8'h00);

    // R8
    ram_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && ram_sel) |=> (!$stable(host_addr) || host_rdata == $past(host_wdata)));

endmodule

bind wt_mixer wt_mixer_chk #(.HAW(HAW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .mode       (mode_q),
    .busy       (seq_busy),
    .out_valid  (out_valid),
    .reg_sel    (reg_sel),
    .ram_sel    (ram_sel),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
);

// File: tb/tb_wt_mixer.sv
module tb_wt_mixer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [10:0] host_addr;
    logic        host_we;
    logic [7:0]  host_wdata;
    logic [7:0]  host_rdata;
    logic        tick;
    logic        out_valid;
    logic [7:0]  out_left;
    logic [7:0]  out_right;

    always #10 clk = ~clk;

    wt_mixer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .tick       (tick),
        .out_valid  (out_valid),
        .out_left   (out_left),
        .out_right  (out_right)
    );

    int n_run = 0;
    int n_fail = 0;
    int n_out = 0;
    bit finished = 0;

    logic [7:0]  ram_m [1024];
    logic [23:0] ph_m  [4];
    logic [23:0] inc_m [4];
    logic [7:0]  exp_q [$];
    logic [7:0]  mon_e;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid === 1'b1) begin
            n_out++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R6/R9 unexpected output", int'(out_left), 0);
            end else begin
                mon_e = exp_q.pop_front();
                check(out_left == mon_e,  "R5 left mix",  int'(out_left),  int'(mon_e));
                check(out_right == mon_e, "R5 right mix", int'(out_right), int'(mon_e));
            end
        end
    end

    task automatic hwr(input int a, input int d);
        @(negedge clk);
        host_addr  = 11'(a);
        host_wdata = 8'(d);
        host_we    = 1'b1;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic hrd(input int a, output int d);
        @(negedge clk);
        host_addr = 11'(a);
        #1 d = int'(host_rdata);
    endtask

    task automatic wr_word(input int v, input int word, input logic [31:0] val);
        for (int b = 0; b < 4; b++) hwr(8 * v + 4 * word + b, int'(val[8 * (3 - b) +: 8]));
        if (word != 0) inc_m[v] = val[23:0];
        else           ph_m[v]  = val[23:0];
    endtask

    task automatic chk_phase(input int v, input string tag);
        int d;
        logic [31:0] got;
        got = '0;
        for (int b = 0; b < 4; b++) begin
            hrd(8 * v + b, d);
            got[8 * (3 - b) +: 8] = 8'(d);
        end
        check(got == {8'h00, ph_m[v]}, tag, int'(got), int'({8'h00, ph_m[v]}));
    endtask

    // driver-side model: pushes one expected output per accepted tick
    task automatic model_tick(input int cv, input int cb, input int cd);
        int sum;
        logic [23:0] adv;
        logic [31:0] w;
        sum = 0;
        for (int v = 0; v < 4; v++) begin
            adv = ph_m[v] + inc_m[v];
            sum += int'(ram_m[(v / 2) * 512 + int'(adv[23:15])]);
            if (v == cv) begin
                w = {8'h00, ph_m[v]};
                w[8 * (3 - cb) +: 8] = 8'(cd);
                ph_m[v] = w[23:0];
            end else begin
                ph_m[v] = adv;
            end
        end
        exp_q.push_back(8'(sum >> 2));
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic run_tick();
        model_tick(-1, 0, 0);
        pulse_tick();
        repeat (7) @(negedge clk);
    endtask

    // host phase byte write aligned with the store of voice k (R7)
    task automatic collide_tick(input int k, input int b, input int d);
        model_tick(k, b, d);
        pulse_tick();
        repeat (k) @(negedge clk);
        host_addr  = 11'(8 * k + b);
        host_wdata = 8'(d);
        host_we    = 1'b1;
        @(negedge clk);
        host_we    = 1'b0;
        repeat (7) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int d;
        int outs;
        logic [23:0] saved [4];
        rst_n = 1'b0; host_addr = '0; host_we = 1'b0; host_wdata = '0; tick = 1'b0;
        for (int v = 0; v < 4; v++) begin ph_m[v] = '0; inc_m[v] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(out_left == 8'h00, "R1 out_left", int'(out_left), 0);
        hrd(32'h20, d);
        check(d == 0, "R1 mode", d, 0);
        chk_phase(2, "R1 phase");

        // R8 sample RAM load and readback
        for (int a = 0; a < 1024; a++) begin
            ram_m[a] = (a < 512) ? 8'((a * 7 + 3) & 255) : 8'(((a * 13) ^ 8'hA5) & 255);
            hwr(32'h400 + a, int'(ram_m[a]));
        end
        hrd(32'h400 + 5, d);   check(d == int'(ram_m[5]),   "R8 table A read", d, int'(ram_m[5]));
        hrd(32'h400 + 700, d); check(d == int'(ram_m[700]), "R8 table B read", d, int'(ram_m[700]));

        // R2 register map, big-endian layout, dropped top byte
        wr_word(0, 0, 32'h0000_0000); wr_word(0, 1, 32'h0000_8000);
        wr_word(1, 0, 32'h0010_0000); wr_word(1, 1, 32'hFF01_2345);
        wr_word(2, 0, 32'h00FF_0000); wr_word(2, 1, 32'h0002_0000);
        wr_word(3, 0, 32'h0000_ABCD); wr_word(3, 1, 32'h000F_FFFF);
        hrd(8 * 1 + 4 + 0, d); check(d == 0,    "R2 top byte dropped", d, 0);
        hrd(8 * 1 + 4 + 1, d); check(d == 8'h01, "R2 incr byte 1", d, 8'h01);
        hrd(8 * 3 + 3, d);     check(d == 8'hCD, "R2 phase byte 3", d, 8'hCD);
        hwr(32'h20, 2);
        hrd(32'h20, d);        check(d == 2, "R2 mode readback", d, 2);

        // R3 R4 R5 R10 several ticks, voice 2 wraps on the first one
        for (int t = 0; t < 6; t++) run_tick();
        for (int v = 0; v < 4; v++) chk_phase(v, "R3 R10 phase after ticks");

        // R5 output timing: low at fifth falling edge, high at sixth
        model_tick(-1, 0, 0);
        pulse_tick();
        repeat (4) @(negedge clk);
        #1 check(out_valid == 1'b0, "R5 early valid", int'(out_valid), 0);
        @(negedge clk);
        #1 check(out_valid == 1'b1, "R5 valid timing", int'(out_valid), 1);
        repeat (3) @(negedge clk);

        // R4 new increments that sweep the upper table
        wr_word(2, 1, 32'h0031_8000); wr_word(3, 1, 32'h0007_8000);
        for (int t = 0; t < 4; t++) run_tick();

        // R6 mode 0 and mode 3: no output, phases frozen
        for (int m = 0; m < 4; m += 3) begin
            hwr(32'h20, m);
            for (int v = 0; v < 4; v++) saved[v] = ph_m[v];
            outs = n_out;
            pulse_tick();
            repeat (8) @(negedge clk);
            check(n_out == outs, "R6 no output", n_out - outs, 0);
            for (int v = 0; v < 4; v++) chk_phase(v, "R6 phase held");
        end
        hwr(32'h20, 2);

        // R9 second tick during a running sequence
        outs = n_out;
        model_tick(-1, 0, 0);
        pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (8) @(negedge clk);
        check(n_out == outs + 1, "R9 one output per tick", n_out - outs, 1);
        for (int v = 0; v < 4; v++) chk_phase(v, "R9 phase advanced once");

        // R7 host write colliding with the store of voice k
        collide_tick(0, 1, 8'h42);
        chk_phase(0, "R7 collision voice 0");
        collide_tick(2, 3, 8'h99);
        chk_phase(2, "R7 collision voice 2");
        collide_tick(3, 2, 8'h5A);
        chk_phase(3, "R7 collision voice 3");
        run_tick();

        check(exp_q.size() == 0, "R5 missing outputs", exp_q.size(), 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule